// File: doc/BRIEF.md
# Cross-Compare Logic Self-Test Harness

The harness self-tests a bank of identical small logic blocks. Each block is combinational logic followed by one output register. After `start`, binary counters step through every input vector, one vector per clock. The same vectors go to all copies of the block. The copies are split into groups. An analyzer per group checks on every cycle that all members of its group produced the same response. No stored expected responses or signatures are needed, because the copies act as references for each other.

Several counters drive the copies, assigned round-robin, so that members of one group are fed by different counters. A broken counter then shows up as a disagreement inside a group instead of a silent false agreement. When an analyzer sees a disagreement, its fail bit sets and feeds back into its own logic, so it stops evaluating and holds the failure until reset. `done` rises after the final vector has been compared. `pass` reports a clean run. The copies are a parameterised behavioural model. One copy can be given an injected fault through parameters, so the harness's own detection can be verified.

Top module: `lbist_harness`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done`, `pass` and every bit of `fail` are 0.
- R2: When `start` is sampled high in the idle state, `done` rises on exactly the 2^IN_W+1-th rising edge after that edge. It is 0 before that edge and stays high until reset.
- R3: When no copy is faulty, a run ends with `done`=1, `pass`=1 and `fail` all zero.
- R4: Copies g*GROUP to g*GROUP+GROUP-1 belong to analyzer g. A response disagreement for the vector applied k edges after the start edge sets `fail[g]` on edge k+2. Only analyzer g is affected; the other fail bits stay 0. In the behavioural model the all-zero vector gives an all-zero response, so a stuck-at-1 output is caught on vector 0.
- R5: A set fail bit stays set through the rest of the run, after `done`, and through further `start` pulses. Only `rst` clears it.
- R6: `pass` is 1 only when `done` is 1 and no fail bit is set. A faulty run ends with `done`=1 and `pass`=0.
- R7: `start` is ignored outside the idle state. A pulse in mid-run leaves the timing of `done` unchanged. A pulse after `done` leaves `done` and `pass` unchanged.
- R8: The response to the final vector (all ones) is compared before `done` rises. A fault that corrupts only that vector sets its fail bit on the same edge on which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a self-test run when the harness is idle |
| done | output | 1 | High once every vector has been applied and compared |
| pass | output | 1 | High when done with no analyzer failure |
| fail | output | NUM_ANA | Sticky failure flag per analyzer group |

## Verification
Every result is tied to a fixed edge count after the edge that samples `start`. Vector k is registered by the copies on edge k+1 and reaches the fail bits on edge k+2. `done` rises on edge 2^IN_W+1. The bench drives and samples on falling edges. It counts edges from the start pulse and checks each output on the edge where it is due and also on the edge before, so a result that arrives one cycle early or late is reported. Three harness instances, one clean, one with a stuck-at output and one with a fault on the last vector only, cover each analyzer's detection, latching and isolation.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } lbist_state_e;
endpackage

// File: rtl/lbist_tpg.sv
module lbist_tpg #(
    parameter int IN_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic [IN_W-1:0] pat
);
    typedef struct packed {
        logic [IN_W-1:0] cnt;
    } tpg_s;

    tpg_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (en) nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign pat = cur_q.cnt;
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut #(
    parameter int   IN_W   = 18,
    parameter int   OUT_W  = 4,
    parameter bit   FAULTY = 1'b0,
    parameter int   FBIT   = 0,
    parameter bit   FVAL   = 1'b0,
    parameter int   FPAT   = -1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  pat,
    output logic [OUT_W-1:0] resp
);
    typedef struct packed {
        logic [OUT_W-1:0] r;
    } cut_s;

    cut_s cur_q, nxt_d;

    always_comb begin
        logic [OUT_W-1:0] f;
        f = '0;
        for (int i = 0; i < IN_W; i++) f[i % OUT_W] = f[i % OUT_W] ^ pat[i];
        for (int j = 0; j < OUT_W; j++) begin
            if (j + OUT_W < IN_W) f[j] = f[j] ^ (pat[j] & pat[j + OUT_W]);
        end
        if (FAULTY) begin
            if (FPAT < 0)                f[FBIT] = FVAL;
            else if (int'(pat) == FPAT)  f[FBIT] = ~f[FBIT];
        end
        nxt_d.r = f;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign resp = cur_q.r;
endmodule

// File: rtl/lbist_ora.sv
module lbist_ora #(
    parameter int OUT_W = 4,
    parameter int MEMB  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  valid,
    input  logic [MEMB*OUT_W-1:0] resps,
    output logic                  fail
);
    typedef struct packed {
        logic err;
    } ora_s;

    ora_s cur_q, nxt_d;
    logic differ;

    always_comb begin
        differ = 1'b0;
        for (int m = 1; m < MEMB; m++) begin
            if (resps[m*OUT_W +: OUT_W] != resps[0 +: OUT_W]) differ = 1'b1;
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (!cur_q.err && valid && differ) nxt_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign fail = cur_q.err;
endmodule

// File: rtl/lbist_harness.sv
module lbist_harness #(
    parameter int IN_W       = 18,
    parameter int OUT_W      = 4,
    parameter int NUM_BUT    = 8,
    parameter int GROUP      = 4,
    parameter int NUM_TPG    = 2,
    parameter int FAULT_COPY = -1,
    parameter int FAULT_BIT  = 0,
    parameter bit STUCK_VAL  = 1'b0,
    parameter int FAULT_PAT  = -1,
    localparam int NUM_ANA   = (NUM_BUT + GROUP - 1) / GROUP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               done,
    output logic               pass,
    output logic [NUM_ANA-1:0] fail
);
    import lbist_pkg::*;

    typedef struct packed {
        lbist_state_e st;
        logic         valid;
    } ctl_s;

    ctl_s cur_q, nxt_d;
    logic run_en;
    logic last_pat;
    logic cmp_valid_q;
    logic [NUM_TPG-1:0][IN_W-1:0]   pats;
    logic [NUM_BUT*OUT_W-1:0]       resps;

    assign run_en      = (cur_q.st == ST_RUN);
    assign last_pat    = &pats[0];
    assign cmp_valid_q = cur_q.valid;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = run_en;
        case (cur_q.st)
            ST_IDLE:  if (start) nxt_d.st = ST_RUN;
            ST_RUN:   if (last_pat) nxt_d.st = ST_DRAIN;
            ST_DRAIN: nxt_d.st = ST_DONE;
            default:  nxt_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st    <= ST_IDLE;
            cur_q.valid <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar t = 0; t < NUM_TPG; t++) begin : g_tpg
        lbist_tpg #(.IN_W(IN_W)) u_tpg (
            .clk (clk),
            .rst (rst),
            .en  (run_en),
            .pat (pats[t])
        );
    end

    for (genvar k = 0; k < NUM_BUT; k++) begin : g_cut
        lbist_cut #(
            .IN_W   (IN_W),
            .OUT_W  (OUT_W),
            .FAULTY (k == FAULT_COPY),
            .FBIT   (FAULT_BIT),
            .FVAL   (STUCK_VAL),
            .FPAT   (FAULT_PAT)
        ) u_cut (
            .clk  (clk),
            .rst  (rst),
            .pat  (pats[k % NUM_TPG]),
            .resp (resps[k*OUT_W +: OUT_W])
        );
    end

    for (genvar g = 0; g < NUM_ANA; g++) begin : g_ora
        localparam int REST = NUM_BUT - g * GROUP;
        localparam int MEMB = (REST < GROUP) ? REST : GROUP;
        lbist_ora #(.OUT_W(OUT_W), .MEMB(MEMB)) u_ora (
            .clk   (clk),
            .rst   (rst),
            .valid (cur_q.valid),
            .resps (resps[g*GROUP*OUT_W +: MEMB*OUT_W]),
            .fail  (fail[g])
        );
    end

    assign done = (cur_q.st == ST_DONE);
    assign pass = done & ~(|fail);
endmodule

// File: rtl/lbist_harness_chk.sv
module lbist_harness_chk #(
    parameter int NUM_ANA = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               pass,
    input logic [NUM_ANA-1:0] fail,
    input logic               cmp_valid
);
    p_done_hold_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_fail_on_compare_r4: assert property (@(posedge clk) disable iff (rst)
        (fail != $past(fail)) |-> $past(cmp_valid));

    p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ((fail & $past(fail)) == $past(fail)));

    p_pass_clean_r6: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && (fail == '0)));

    p_start_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (done && $stable(fail)));
endmodule

bind lbist_harness lbist_harness_chk #(.NUM_ANA(NUM_ANA)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .cmp_valid (cmp_valid_q)
);

// File: tb/sim_lbist_harness.sv
module sim_lbist_harness;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic       d0, d1, d2, p0, p1, p2;
    logic [1:0] f0, f1, f2;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbist_harness #(.IN_W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .done(d0), .pass(p0), .fail(f0));

    lbist_harness #(.IN_W(W), .FAULT_COPY(6), .FAULT_BIT(2), .STUCK_VAL(1'b1)) u1 (
        .clk(clk), .rst(rst), .start(start), .done(d1), .pass(p1), .fail(f1));

    lbist_harness #(.IN_W(W), .FAULT_COPY(1), .FAULT_BIT(0), .FAULT_PAT(N-1)) u2 (
        .clk(clk), .rst(rst), .start(start), .done(d2), .pass(p2), .fail(f2));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    // leaves the bench just after the edge that samples start
    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        rst = 1'b1;
        tick(2);
        chk(32'({d0, p0, f0}), 0, "R1 u0 in reset");
        chk(32'({d1, p1, f1}), 0, "R1 u1 in reset");
        rst = 1'b0;
        tick(1);
        chk(32'({d0, p0, f0}), 0, "R1 u0 after reset");
        chk(32'({d2, p2, f2}), 0, "R1 u2 after reset");
    endtask

    task automatic t_clean_run();
        do_reset();
        tick(1);
        pulse_start();
        tick(99);
        pulse_start();                      // mid-run pulse, R7
        tick(N - 100);
        chk(32'(d0), 0, "R2 done before final edge");
        tick(1);
        chk(32'(d0), 1, "R2 done on edge N+1 (R7 mid-run start ignored)");
        chk(32'(f0), 0, "R3 no fail on clean run");
        chk(32'(p0), 1, "R3 pass on clean run");
        pulse_start();
        tick(5);
        chk(32'({d0, p0}), 2'b11, "R7 start after done ignored");
        chk(32'(d0), 1, "R2 done held");
    endtask

    task automatic t_stuck_fault();
        do_reset();
        pulse_start();
        tick(1);
        chk(32'(f1), 0, "R4 fail not before edge 2");
        tick(1);
        chk(32'(f1), 32'h2, "R4 analyzer 1 flags stuck copy on edge 2");
        tick(N - 2);
        chk(32'(f1), 32'h2, "R5 fail held in run");
        tick(1);
        chk(32'({d1, p1}), 2'b10, "R6 done with pass low");
        chk(32'(f1), 32'h2, "R4 analyzer 0 untouched");
        pulse_start();
        tick(20);
        chk(32'(f1), 32'h2, "R5 fail held after done");
        do_reset();
        tick(1);
        chk(32'(f1), 0, "R5 reset clears fail");
    endtask

    task automatic t_last_vector();
        do_reset();
        pulse_start();
        tick(N);
        chk(32'({d2, f2}), 0, "R8 nothing flagged before last compare");
        tick(1);
        chk(32'(f2), 32'h1, "R8 last vector fault flagged");
        chk(32'({d2, p2}), 2'b10, "R8 done with pass low");
    endtask

    initial begin
        t_reset_r1();
        t_clean_run();
        t_stuck_fault();
        t_last_vector();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end
endmodule